// File: doc/BRIEF.md
# Row-Column Organized Static RAM

This block is a single-port, word-addressed static RAM of 32768 words of 8 bits. At its ports it behaves as a plain flat memory: a clock, a chip select, a write enable, a 15-bit address, an 8-bit data input and an 8-bit data output. Inside, the bits are kept in a square array of 512 rows of 512 bits. No single decoder produces 32768 outputs. Instead, the address is cut into two fields, each with its own small decoder.

The upper address field drives a row decoder. That decoder raises exactly one word line, and the whole 512-bit row on that line is read out. The lower field then picks one 8-bit group out of that wide row for the output. A write merges the new byte into the selected group of the row that was read. The merged row is stored back on the rising clock edge, so the other groups of the row come back unchanged. Reads are combinational: the output follows the address with no clock edge in between.

Top module: `rc_sram`

## Requirements
- R1: The memory holds 32768 distinct 8-bit words, addressed by a 15-bit address, and every address from 0 to 32767 can be written and read back.
- R2: Address bits [14:6] select the row and bits [5:0] select the 8-bit group within that row. Group c occupies bits [8c+7:8c] of the row, so addresses 63 and 64 lie in different rows.
- R3: At most one word line is active at any time, and none is active while chip select is low.
- R4: With chip select and write enable both high at a rising clock edge, the data input is stored at the addressed location. It is visible on the data output once that address is read after the edge.
- R5: With chip select high and write enable low, the data output shows the word stored at the current address, combinationally, without waiting for a clock edge.
- R6: With chip select low, the data output is zero and a rising clock edge changes no stored word, whatever the write enable, address and data inputs are.
- R7: A write to one group of a row leaves the other 63 groups of that row unchanged.
- R8: A write changes no row other than the addressed one.
- R9: Seen from the ports, the memory behaves exactly like a flat 32768 x 8 memory: each location returns the last value written to it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; writes take effect on its rising edge |
| cs | input | 1 | Chip select; must be high for any access |
| we | input | 1 | Write enable; high selects a write when cs is high |
| addr | input | 15 | Word address: row in the upper 9 bits, group in the lower 6 |
| din | input | 8 | Data to be written |
| dout | output | 8 | Word read from the addressed location, zero while cs is low |

## Verification
The bench builds the block with its default parameters: 9 row bits, 6 group bits and 8-bit words. At that size the whole 32768-word address space fits in a single run. Every location is written with an arithmetic pattern of its address and then read back, which covers the row boundary between addresses 63 and 64 and both ends of the range. One row is then refilled group by group and one group is overwritten again. This shows that neighbours in the same row and the rows above and below are left alone. Writes attempted with chip select low are shown to leave the stored words intact.

// File: rtl/sram_rc_pkg.sv
package sram_rc_pkg;
    localparam int unsigned DEF_ROW_BITS = 9;
    localparam int unsigned DEF_COL_BITS = 6;
    localparam int unsigned DEF_DATA_W   = 8;

    typedef enum logic [1:0] {
        ACC_IDLE  = 2'd0,
        ACC_READ  = 2'd1,
        ACC_WRITE = 2'd2
    } acc_kind_e;
endpackage

// File: rtl/sram_rc_row_dec.sv
module sram_rc_row_dec #(
    parameter int unsigned ROW_BITS = 9,
    localparam int unsigned ROWS    = 1 << ROW_BITS
) (
    input  logic                en,
    input  logic [ROW_BITS-1:0] row,
    output logic [ROWS-1:0]     wl
);
    always_comb begin
        wl = '0;
        if (en) begin
            wl[row] = 1'b1;
        end
    end

    // Word line checks
    always_comb begin
        p_single_wordline_r3: assert ($onehot0(wl))
            else $error("more than one word line active");
        if (!en) begin
            p_idle_no_wordline_r3: assert (wl == '0)
                else $error("word line active while disabled");
        end
    end
endmodule

// File: rtl/sram_rc_col_sel.sv
module sram_rc_col_sel #(
    parameter int unsigned COL_BITS = 6,
    parameter int unsigned DATA_W   = 8,
    localparam int unsigned ROW_W   = (1 << COL_BITS) * DATA_W
) (
    input  logic                en,
    input  logic [ROW_W-1:0]    row_bits,
    input  logic [COL_BITS-1:0] col,
    output logic [DATA_W-1:0]   word
);
    int unsigned base;

    always_comb begin
        base = int'(col) * DATA_W;
        word = '0;
        if (en) begin
            word = row_bits[base +: DATA_W];
        end
    end
endmodule

// File: rtl/sram_rc_col_merge.sv
module sram_rc_col_merge #(
    parameter int unsigned COL_BITS = 6,
    parameter int unsigned DATA_W   = 8,
    localparam int unsigned ROW_W   = (1 << COL_BITS) * DATA_W
) (
    input  logic [ROW_W-1:0]    old_row,
    input  logic [COL_BITS-1:0] col,
    input  logic [DATA_W-1:0]   din,
    output logic [ROW_W-1:0]    new_row_d
);
    int unsigned base;

    always_comb begin
        base      = int'(col) * DATA_W;
        new_row_d = old_row;
        new_row_d[base +: DATA_W] = din;
    end
endmodule

// File: rtl/sram_rc_array.sv
module sram_rc_array #(
    parameter int unsigned ROW_BITS = 9,
    parameter int unsigned ROW_W    = 512,
    localparam int unsigned ROWS    = 1 << ROW_BITS
) (
    input  logic             clk,
    input  logic             wr_en,
    input  logic [ROWS-1:0]  wl,
    input  logic [ROW_W-1:0] wr_row,
    output logic [ROW_W-1:0] rd_row
);
    logic [ROW_W-1:0] rows_q [ROWS];

    // Storage: only the row on the active word line is rewritten
    always_ff @(posedge clk) begin
        for (int r = 0; r < int'(ROWS); r++) begin
            if (wr_en && wl[r]) begin
                rows_q[r] <= wr_row;
            end
        end
    end

    // Read out the row on the active word line (AND-OR bitline model)
    always_comb begin
        rd_row = '0;
        for (int r = 0; r < int'(ROWS); r++) begin
            rd_row = rd_row | (rows_q[r] & {ROW_W{wl[r]}});
        end
    end

    always_comb begin
        if (wr_en) begin
            p_write_one_row_r8: assert ($onehot(wl))
                else $error("write without exactly one word line");
        end
    end
endmodule

// File: rtl/rc_sram.sv
module rc_sram
    import sram_rc_pkg::*;
#(
    parameter int unsigned ROW_BITS = DEF_ROW_BITS,
    parameter int unsigned COL_BITS = DEF_COL_BITS,
    parameter int unsigned DATA_W   = DEF_DATA_W,
    localparam int unsigned ADDR_W  = ROW_BITS + COL_BITS,
    localparam int unsigned ROWS    = 1 << ROW_BITS,
    localparam int unsigned ROW_W   = (1 << COL_BITS) * DATA_W
) (
    input  logic              clk,
    input  logic              cs,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout
);
    acc_kind_e             kind_d;
    logic                  rows_en;
    logic                  wr_en;
    logic [ROW_BITS-1:0]   row_sel;
    logic [COL_BITS-1:0]   col_sel;
    logic [ROWS-1:0]       wl;
    logic [ROW_W-1:0]      rd_row;
    logic [ROW_W-1:0]      wr_row_d;
    logic [ROW_W-1:0]      grp_mask;

    always_comb begin
        row_sel = addr[ADDR_W-1:COL_BITS];
        col_sel = addr[COL_BITS-1:0];
        if (!cs) begin
            kind_d = ACC_IDLE;
        end else if (we) begin
            kind_d = ACC_WRITE;
        end else begin
            kind_d = ACC_READ;
        end
        rows_en = (kind_d != ACC_IDLE);
        wr_en   = (kind_d == ACC_WRITE);
    end

    sram_rc_row_dec #(.ROW_BITS(ROW_BITS)) u_row_dec (
        .en  (rows_en),
        .row (row_sel),
        .wl  (wl)
    );

    sram_rc_array #(.ROW_BITS(ROW_BITS), .ROW_W(ROW_W)) u_array (
        .clk    (clk),
        .wr_en  (wr_en),
        .wl     (wl),
        .wr_row (wr_row_d),
        .rd_row (rd_row)
    );

    sram_rc_col_merge #(.COL_BITS(COL_BITS), .DATA_W(DATA_W)) u_merge (
        .old_row   (rd_row),
        .col       (col_sel),
        .din       (din),
        .new_row_d (wr_row_d)
    );

    sram_rc_col_sel #(.COL_BITS(COL_BITS), .DATA_W(DATA_W)) u_col_sel (
        .en       (rows_en),
        .row_bits (rd_row),
        .col      (col_sel),
        .word     (dout)
    );

    // Port-level checks across decoder, merge and column select
    always_comb begin
        grp_mask = {{(ROW_W-DATA_W){1'b0}}, {DATA_W{1'b1}}} << (int'(col_sel) * DATA_W);
        if (!cs) begin
            p_dout_quiet_r6: assert (dout == '0)
                else $error("dout not zero while deselected");
        end
        if (wr_en) begin
            p_merge_keeps_neighbours_r7: assert (((wr_row_d ^ rd_row) & ~grp_mask) == '0)
                else $error("write disturbs other groups of the row");
            p_merge_places_data_r4: assert (((wr_row_d & grp_mask) >> (int'(col_sel) * DATA_W)) == ROW_W'(din))
                else $error("write data not placed in selected group");
        end
    end
endmodule

// File: tb/rc_sram_test.sv
module rc_sram_test;
    localparam int AW = 15;
    localparam int DW = 8;
    localparam int NWORDS = 1 << AW;

    logic          clk = 1'b0;
    logic          cs  = 1'b0;
    logic          we  = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] din  = '0;
    logic [DW-1:0] dout;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    rc_sram uut (
        .clk  (clk),
        .cs   (cs),
        .we   (we),
        .addr (addr),
        .din  (din),
        .dout (dout)
    );

    function automatic logic [DW-1:0] fill_pat(int a);
        return DW'((a * 37) ^ (a >> 7) ^ 8'h5C);
    endfunction

    function automatic logic [DW-1:0] grp_pat(int c);
        return DW'(c * 3 + 8'h40);
    endfunction

    task automatic check(logic [DW-1:0] act, logic [DW-1:0] exp, string req, int a);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s addr=%0d actual=%02h expected=%02h", req, a, act, exp);
        end
    endtask

    task automatic wr(int a, logic [DW-1:0] d);
        @(negedge clk);
        cs = 1'b1; we = 1'b1; addr = AW'(a); din = d;
        @(posedge clk);
    endtask

    task automatic rd_check(int a, logic [DW-1:0] exp, string req);
        @(negedge clk);
        cs = 1'b1; we = 1'b0; addr = AW'(a);
        #1;
        check(dout, exp, req, a);
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        // R6: deselected output is zero from the start
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(dout, 8'h00, "R6 idle", 0);

        // R1 R9: fill whole space
        for (int a = 0; a < NWORDS; a++) begin
            wr(a, fill_pat(a));
        end
        // R1 R9 R4: read every location back
        for (int a = 0; a < NWORDS; a++) begin
            rd_check(a, fill_pat(a), "R9 sweep");
        end
        rd_check(NWORDS - 1, fill_pat(NWORDS - 1), "R1 top address");
        rd_check(0, fill_pat(0), "R1 bottom address");

        // R5: output follows address change without a clock edge
        @(negedge clk);
        cs = 1'b1; we = 1'b0; addr = AW'(100);
        #0.5;
        addr = AW'(2000);
        #0.5;
        check(dout, fill_pat(2000), "R5 combinational read", 2000);

        // R2: row boundary between 63 and 64
        wr(63, 8'hC3);
        wr(64, 8'h3C);
        rd_check(63, 8'hC3, "R2 row end");
        rd_check(64, 8'h3C, "R2 next row start");
        rd_check(62, fill_pat(62), "R2 neighbour");
        rd_check(65, fill_pat(65), "R2 neighbour");

        // R6: deselected writes are ignored and output stays zero
        @(negedge clk);
        cs = 1'b0; we = 1'b1; addr = AW'(1234); din = ~fill_pat(1234);
        @(posedge clk);
        @(negedge clk);
        addr = AW'(4321); din = ~fill_pat(4321);
        #1;
        check(dout, 8'h00, "R6 dout deselected", 4321);
        @(posedge clk);
        rd_check(1234, fill_pat(1234), "R6 write ignored");
        rd_check(4321, fill_pat(4321), "R6 write ignored");

        // R7: refill row 5 group by group, overwrite group 17
        for (int c = 0; c < 64; c++) begin
            wr(5 * 64 + c, grp_pat(c));
        end
        wr(5 * 64 + 17, 8'hA5);
        for (int c = 0; c < 64; c++) begin
            rd_check(5 * 64 + c, (c == 17) ? 8'hA5 : grp_pat(c), "R7 same row");
        end
        // R8 R3: rows above and below untouched
        for (int c = 0; c < 64; c++) begin
            rd_check(4 * 64 + c, fill_pat(4 * 64 + c), "R8 row below");
            rd_check(6 * 64 + c, fill_pat(6 * 64 + c), "R3 R8 row above");
        end

        // R4: write then immediate read of same address
        wr(20000, 8'h00);
        rd_check(20000, 8'h00, "R4 write visible");
        wr(20000, 8'hFF);
        rd_check(20000, 8'hFF, "R4 overwrite visible");

        @(negedge clk);
        cs = 1'b0; we = 1'b0;
        done = 1'b1;
        summary();
        $finish;
    end
endmodule